// File: doc/BRIEF.md
# Breakpoint Trigger Fire Gate

This block sits between a native debug trigger's match logic and the trap logic of a hart. It takes the trigger's raw hit and its action code and produces a qualified fire signal. When the action code asks for a breakpoint exception (code 0), the gate stops the trigger from firing in contexts where taking that exception would re-enter a breakpoint handler that cannot yet accept one. Triggers with any other action pass through unchanged. The output is purely combinational, in the same cycle as the hit.

The build-time parameter `HAS_SUPV` selects one of two gating schemes. With supervisor mode built in, the gate uses the interrupt-enable bit of the privilege level that would handle the breakpoint, and follows the breakpoint delegation bits. Without supervisor mode, the block owns a small trigger-control register with a machine trigger-enable bit and a saved copy of it. A trap into machine mode clears the enable bit and saves it, and a machine return restores it. The register is read and written through a plain CSR port, and reads as zero when supervisor mode is built in.

Privilege encoding on `priv_i`: 0 = user, 1 = supervisor, 3 = machine, and 2 is never suppressed.

Top module: `trig_fire_gate`

## Requirements
- R1: When `action_i` is not 0, `fire_o` equals `hit_i` in every mode and configuration.
- R2: When `hit_i` is 0, `fire_o` is 0.
- R3: With `HAS_SUPV`=1, an action-0 hit in machine mode fires only when `m_ie_i` is 1.
- R4: With `HAS_SUPV`=1, an action-0 hit in supervisor mode with `virt_i`=0 is suppressed exactly when `m_deleg_bp_i`=1 and `s_ie_i`=0.
- R5: With `HAS_SUPV`=1, an action-0 hit in supervisor mode with `virt_i`=1 is suppressed exactly when `m_deleg_bp_i`=1, `h_deleg_bp_i`=1 and `vs_ie_i`=0.
- R6: An action-0 hit in user mode is never suppressed, whatever the enable and delegation inputs are.
- R7: With `HAS_SUPV`=0, an action-0 hit in machine mode fires only when control bit 3 (machine trigger enable) is 1. Outside machine mode it always fires, and the delegation and interrupt-enable inputs have no effect.
- R8: With `HAS_SUPV`=0, the control register resets to 0. Only bit 3 (enable) and bit 7 (saved enable) are writable, all other bits read 0, and a write shows on `ctl_rdata_o` from the next cycle.
- R9: With `HAS_SUPV`=0, `trap_m_i` moves bit 3 into bit 7 and clears bit 3, taking effect in the next cycle.
- R10: With `HAS_SUPV`=0, `mret_i` copies bit 7 into bit 3 and leaves bit 7 unchanged, taking effect in the next cycle.
- R11: In the same cycle, a trap wins over a machine return, and either event wins over a CSR write. A write that coincides with an event is lost.
- R12: With `HAS_SUPV`=1, `ctl_rdata_o` is always 0 and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virt_i | input | 1 | Virtualization active |
| m_ie_i | input | 1 | Machine interrupt enable |
| s_ie_i | input | 1 | Supervisor interrupt enable |
| vs_ie_i | input | 1 | Virtual-supervisor interrupt enable |
| m_deleg_bp_i | input | 1 | Breakpoint exception delegated out of M |
| h_deleg_bp_i | input | 1 | Breakpoint exception delegated to VS |
| hit_i | input | 1 | Raw trigger match |
| action_i | input | ACT_W | Trigger action code; 0 = breakpoint exception |
| trap_m_i | input | 1 | Trap into machine mode this cycle |
| mret_i | input | 1 | Machine return this cycle |
| ctl_we_i | input | 1 | Control register write enable |
| ctl_wdata_i | input | XLEN | Control register write data |
| ctl_rdata_o | output | XLEN | Control register read data |
| fire_o | output | 1 | Qualified trigger fire |

## Verification
The control register can see a software write and a trap or machine return in the same cycle. The two hardware events can also arrive together. The bench drives these combinations on one clock edge from known register states. It then reads the register back and expects the event result with the written value discarded, or the trap result when both events coincide. The fire output is also checked right after each register change, so a stale enable bit would show up as a wrong fire value.

// File: rtl/trig_gate_pkg.sv
package trig_gate_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_R = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  localparam int unsigned CTL_EN_BIT   = 3;
  localparam int unsigned CTL_PREV_BIT = 7;
  localparam int unsigned CTL_MIN_W    = CTL_PREV_BIT + 1;

  typedef struct packed {
    logic prev_en;
    logic en;
  } ctl_state_t;
endpackage

// File: rtl/tg_supv_cond.sv
module tg_supv_cond
  import trig_gate_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       m_ie_i,
  input  logic       s_ie_i,
  input  logic       vs_ie_i,
  input  logic       m_deleg_bp_i,
  input  logic       h_deleg_bp_i,
  output logic       allow_o
);
  priv_e priv;
  logic  block_m, block_hs, block_vs;

  assign priv = priv_e'(priv_i);

  always_comb begin
    block_m  = 1'b0;
    block_hs = 1'b0;
    block_vs = 1'b0;
    unique case (priv)
      PRIV_M: block_m = ~m_ie_i;
      PRIV_S: begin
        // breakpoint would land in HS or VS handler only when delegated
        block_hs = ~virt_i & m_deleg_bp_i & ~s_ie_i;
        block_vs = virt_i & m_deleg_bp_i & h_deleg_bp_i & ~vs_ie_i;
      end
      default: ;
    endcase
  end

  assign allow_o = ~(block_m | block_hs | block_vs);
endmodule

// File: rtl/tg_bare_cond.sv
module tg_bare_cond
  import trig_gate_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       m_en_i,
  output logic       allow_o
);
  priv_e priv;
  assign priv    = priv_e'(priv_i);
  assign allow_o = (priv != PRIV_M) | m_en_i;
endmodule

// File: rtl/tg_ctl_reg.sv
module tg_ctl_reg
  import trig_gate_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            trap_m_i,
  input  logic            mret_i,
  output logic            m_en_o,
  output logic [XLEN-1:0] rdata_o
);
  ctl_state_t q, d;

  always_comb begin
    d = q;
    if (trap_m_i) begin
      d.prev_en = q.en;
      d.en      = 1'b0;
    end else if (mret_i) begin
      d.en      = q.prev_en;
    end else if (we_i) begin
      d.en      = wdata_i[CTL_EN_BIT];
      d.prev_en = wdata_i[CTL_PREV_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  always_comb begin
    rdata_o               = '0;
    rdata_o[CTL_EN_BIT]   = q.en;
    rdata_o[CTL_PREV_BIT] = q.prev_en;
  end

  assign m_en_o = q.en;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/trig_fire_gate.sv
module trig_fire_gate
  import trig_gate_pkg::*;
#(
  parameter bit          HAS_SUPV = 1'b1,
  parameter int unsigned XLEN     = 32,
  parameter int unsigned ACT_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic             m_ie_i,
  input  logic             s_ie_i,
  input  logic             vs_ie_i,
  input  logic             m_deleg_bp_i,
  input  logic             h_deleg_bp_i,
  input  logic             hit_i,
  input  logic [ACT_W-1:0] action_i,
  input  logic             trap_m_i,
  input  logic             mret_i,
  input  logic             ctl_we_i,
  input  logic [XLEN-1:0]  ctl_wdata_i,
  output logic [XLEN-1:0]  ctl_rdata_o,
  output logic             fire_o
);
  localparam logic [ACT_W-1:0] ACT_BREAK = '0;

  logic allow;
  logic is_break;

  assign is_break = (action_i == ACT_BREAK);

  if (XLEN < CTL_MIN_W) begin : g_bad_xlen
    initial $error("XLEN too small for control register");
  end

  if (HAS_SUPV) begin : g_supv
    tg_supv_cond u_cond (
      .priv_i       (priv_i),
      .virt_i       (virt_i),
      .m_ie_i       (m_ie_i),
      .s_ie_i       (s_ie_i),
      .vs_ie_i      (vs_ie_i),
      .m_deleg_bp_i (m_deleg_bp_i),
      .h_deleg_bp_i (h_deleg_bp_i),
      .allow_o      (allow)
    );
    assign ctl_rdata_o = '0;
    logic unused_ctl;
    assign unused_ctl = ^{clk_i, rst_ni, trap_m_i, mret_i, ctl_we_i, ctl_wdata_i};
  end else begin : g_bare
    logic m_en;
    tg_ctl_reg #(.XLEN(XLEN)) u_ctl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (ctl_we_i),
      .wdata_i  (ctl_wdata_i),
      .trap_m_i (trap_m_i),
      .mret_i   (mret_i),
      .m_en_o   (m_en),
      .rdata_o  (ctl_rdata_o)
    );
    tg_bare_cond u_cond (
      .priv_i  (priv_i),
      .m_en_i  (m_en),
      .allow_o (allow)
    );
    // delegation is hard-wired off in this configuration
    logic unused_supv;
    assign unused_supv = ^{virt_i, m_ie_i, s_ie_i, vs_ie_i, m_deleg_bp_i, h_deleg_bp_i};
  end

  assign fire_o = hit_i & (~is_break | allow);
endmodule

// File: rtl/trig_fire_gate_chk.sv
module trig_fire_gate_chk #(
  parameter bit          HAS_SUPV = 1'b1,
  parameter int unsigned XLEN     = 32,
  parameter int unsigned ACT_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       priv_i,
  input logic             virt_i,
  input logic             m_ie_i,
  input logic             s_ie_i,
  input logic             vs_ie_i,
  input logic             m_deleg_bp_i,
  input logic             h_deleg_bp_i,
  input logic             hit_i,
  input logic [ACT_W-1:0] action_i,
  input logic             trap_m_i,
  input logic             mret_i,
  input logic             ctl_we_i,
  input logic [XLEN-1:0]  ctl_wdata_i,
  input logic [XLEN-1:0]  ctl_rdata_o,
  input logic             fire_o
);
  logic [XLEN-1:0] ctl_mask;
  always_comb begin
    ctl_mask    = '0;
    ctl_mask[3] = 1'b1;
    ctl_mask[7] = 1'b1;
  end

  a_r1_other_action_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (action_i != '0) |-> (fire_o == hit_i));

  a_r2_no_hit_no_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |-> !fire_o);

  a_r6_user_never_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i == 2'd0) |-> (fire_o == hit_i));

  if (HAS_SUPV) begin : g_supv
    a_r3_machine_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (priv_i == 2'd3 && action_i == '0) |-> (fire_o == (hit_i & m_ie_i)));

    a_r4_hs_deleg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (priv_i == 2'd1 && !virt_i && action_i == '0 && hit_i)
        |-> (fire_o == !(m_deleg_bp_i && !s_ie_i)));

    a_r5_vs_deleg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (priv_i == 2'd1 && virt_i && action_i == '0 && hit_i)
        |-> (fire_o == !(m_deleg_bp_i && h_deleg_bp_i && !vs_ie_i)));

    a_r12_no_ctl_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctl_rdata_o == '0);
  end else begin : g_bare
    a_r7_machine_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (priv_i == 2'd3 && action_i == '0) |-> (fire_o == (hit_i & ctl_rdata_o[3])));

    a_r8_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_rdata_o & ~ctl_mask) == '0);

    a_r8_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_we_i && !trap_m_i && !mret_i) |=> (ctl_rdata_o == ($past(ctl_wdata_i) & ctl_mask)));

    a_r9_trap_saves: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_m_i |=> (!ctl_rdata_o[3] && ctl_rdata_o[7] == $past(ctl_rdata_o[3])));

    a_r10_mret_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mret_i && !trap_m_i) |=> (ctl_rdata_o[3] == $past(ctl_rdata_o[7])
                                 && ctl_rdata_o[7] == $past(ctl_rdata_o[7])));
  end
endmodule

bind trig_fire_gate trig_fire_gate_chk #(
  .HAS_SUPV (HAS_SUPV),
  .XLEN     (XLEN),
  .ACT_W    (ACT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .priv_i       (priv_i),
  .virt_i       (virt_i),
  .m_ie_i       (m_ie_i),
  .s_ie_i       (s_ie_i),
  .vs_ie_i      (vs_ie_i),
  .m_deleg_bp_i (m_deleg_bp_i),
  .h_deleg_bp_i (h_deleg_bp_i),
  .hit_i        (hit_i),
  .action_i     (action_i),
  .trap_m_i     (trap_m_i),
  .mret_i       (mret_i),
  .ctl_we_i     (ctl_we_i),
  .ctl_wdata_i  (ctl_wdata_i),
  .ctl_rdata_o  (ctl_rdata_o),
  .fire_o       (fire_o)
);

// File: tb/trig_fire_gate_tb.sv
module trig_fire_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 32;
  localparam int ACT_W      = 4;
  localparam int NVEC       = 16;

  // {tag[3:0], priv[1:0], virt, m_ie, s_ie, vs_ie, m_deleg, h_deleg, hit, act_nz, exp_supv, exp_bare}
  // bare-config expectations assume control register = 0
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd3, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 R7
    {4'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 R7
    {4'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R1
    {4'd2, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
    {4'd4, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 R7
    {4'd4, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R4
    {4'd4, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R4
    {4'd5, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R5
    {4'd5, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R5
    {4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R5
    {4'd5, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R5
    {4'd6, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R6
    {4'd6, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R6
    {4'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R1
    {4'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
    {4'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}  // R1
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       priv_i = '0;
  logic             virt_i = 1'b0, m_ie_i = 1'b0, s_ie_i = 1'b0, vs_ie_i = 1'b0;
  logic             m_deleg_bp_i = 1'b0, h_deleg_bp_i = 1'b0, hit_i = 1'b0;
  logic [ACT_W-1:0] action_i = '0;
  logic             trap_m_i = 1'b0, mret_i = 1'b0, ctl_we_i = 1'b0;
  logic [XLEN-1:0]  ctl_wdata_i = '0;
  logic [XLEN-1:0]  rd_s, rd_b;
  logic             fire_s, fire_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  trig_fire_gate #(.HAS_SUPV(1'b1), .XLEN(XLEN), .ACT_W(ACT_W)) dut_i (
    .clk_i, .rst_ni, .priv_i, .virt_i, .m_ie_i, .s_ie_i, .vs_ie_i,
    .m_deleg_bp_i, .h_deleg_bp_i, .hit_i, .action_i, .trap_m_i, .mret_i,
    .ctl_we_i, .ctl_wdata_i, .ctl_rdata_o(rd_s), .fire_o(fire_s)
  );

  trig_fire_gate #(.HAS_SUPV(1'b0), .XLEN(XLEN), .ACT_W(ACT_W)) dut_bare_i (
    .clk_i, .rst_ni, .priv_i, .virt_i, .m_ie_i, .s_ie_i, .vs_ie_i,
    .m_deleg_bp_i, .h_deleg_bp_i, .hit_i, .action_i, .trap_m_i, .mret_i,
    .ctl_we_i, .ctl_wdata_i, .ctl_rdata_o(rd_b), .fire_o(fire_b)
  );

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply control events for one edge, then read back after it
  task automatic ctl_cycle(input logic we, input logic [XLEN-1:0] wd, input logic trap, input logic mret);
    @(negedge clk_i);
    ctl_we_i = we; ctl_wdata_i = wd; trap_m_i = trap; mret_i = mret;
    @(negedge clk_i);
    ctl_we_i = 1'b0; ctl_wdata_i = '0; trap_m_i = 1'b0; mret_i = 1'b0;
    #1;
  endtask

  task automatic m_break_hit();
    priv_i = 2'd3; virt_i = 1'b0; m_ie_i = 1'b0; hit_i = 1'b1; action_i = '0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // reset state: R8 R12
    check("R8 reset bare reg", rd_b, '0);
    check("R12 reset supv reg", rd_s, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      v = VEC[i];
      priv_i = v[11:10]; virt_i = v[9]; m_ie_i = v[8]; s_ie_i = v[7]; vs_ie_i = v[6];
      m_deleg_bp_i = v[5]; h_deleg_bp_i = v[4]; hit_i = v[3];
      action_i = v[2] ? ((i % 2 == 0) ? ACT_W'(1) : ACT_W'(15)) : '0;
      #1;
      check($sformatf("R%0d vec%0d supv fire", v[15:12], i), {31'd0, fire_s}, {31'd0, v[1]});
      check($sformatf("R%0d vec%0d bare fire", v[15:12], i), {31'd0, fire_b}, {31'd0, v[0]});
      @(negedge clk_i);
    end

    // R8: write all ones, only bits 3 and 7 stick; R12: supv stays 0
    ctl_cycle(1'b1, '1, 1'b0, 1'b0);
    check("R8 write mask", rd_b, 32'h88);
    check("R12 supv write ignored", rd_s, '0);
    m_break_hit();
    check("R7 enabled machine fires", {31'd0, fire_b}, 32'd1);
    check("R3 supv mie=0 blocks", {31'd0, fire_s}, 32'd0);

    // R7: delegation inputs ignored in bare config
    priv_i = 2'd1; m_deleg_bp_i = 1'b1; s_ie_i = 1'b0; #1;
    check("R7 bare S-mode deleg ignored", {31'd0, fire_b}, 32'd1);
    m_deleg_bp_i = 1'b0; s_ie_i = 1'b0;

    // R9 trap: 0x88 -> 0x80
    ctl_cycle(1'b0, '0, 1'b1, 1'b0);
    check("R9 trap saves enable", rd_b, 32'h80);
    m_break_hit();
    check("R9 trap disables machine fire", {31'd0, fire_b}, 32'd0);

    // R10 mret: 0x80 -> 0x88
    ctl_cycle(1'b0, '0, 1'b0, 1'b1);
    check("R10 mret restores", rd_b, 32'h88);
    check("R10 fire after mret", {31'd0, fire_b}, 32'd1);

    // nested traps: 0x08 -> 0x80 -> 0x00, mret -> 0x00
    ctl_cycle(1'b1, 32'h08, 1'b0, 1'b0);
    check("R8 write enable only", rd_b, 32'h08);
    ctl_cycle(1'b0, '0, 1'b1, 1'b0);
    check("R9 first trap", rd_b, 32'h80);
    ctl_cycle(1'b0, '0, 1'b1, 1'b0);
    check("R9 second trap", rd_b, 32'h00);
    ctl_cycle(1'b0, '0, 1'b0, 1'b1);
    check("R10 mret keeps prev", rd_b, 32'h00);

    // R11: write with trap from 0x00 -> trap result 0x00
    ctl_cycle(1'b1, 32'h08, 1'b1, 1'b0);
    check("R11 trap beats write", rd_b, 32'h00);
    ctl_cycle(1'b1, 32'h88, 1'b0, 1'b0);
    check("R8 write both bits", rd_b, 32'h88);
    ctl_cycle(1'b1, 32'h00, 1'b0, 1'b1);
    check("R11 mret beats write", rd_b, 32'h88);
    ctl_cycle(1'b1, 32'h08, 1'b0, 1'b0);
    ctl_cycle(1'b0, '0, 1'b1, 1'b1);
    check("R11 trap beats mret", rd_b, 32'h80);
    m_break_hit();
    check("R11 fire blocked after trap", {31'd0, fire_b}, 32'd0);
    check("R12 supv reg still zero", rd_s, '0);

    // R1 with register cleared in machine mode
    action_i = ACT_W'(2); #1;
    check("R1 non-break passes bare", {31'd0, fire_b}, 32'd1);
    hit_i = 1'b0; #1;
    check("R2 no hit bare", {31'd0, fire_b}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule